// File: doc/BRIEF.md
# SPI NAND Status Poller with ECC Classification

This block waits for a serial NAND device to finish an internal operation and then judges the error-correction outcome of that operation. When a request is accepted, it reads the device's main status register with a three-byte transaction on a single-lane SPI bus in mode 0. The transaction is the get-feature opcode 0x0F, then the register address 0xC0, then one byte clocked back from the device. If bit 0 of that byte shows the device is still busy, the block waits one microsecond and polls again. It stops when the busy flag clears or when a caller-supplied poll budget runs out.

Once the busy flag clears, the ECC bits of the status byte are turned into one of three verdicts: clean, corrected but due for refresh, or uncorrectable. Seven decoding schemes are available to cover the different ways devices report ECC, and the scheme is chosen per request. Two of the schemes also read a secondary status register at 0xF0 on every poll and combine its bits with the main register. A request enters through a valid/ready handshake. Ready is high only while the block is idle, so a caller that holds valid high simply waits; requests are never queued. Completion is a one-cycle pulse. The verdict, the timeout flag and the last main status byte then stay on their outputs until the next completion.

Top module: `nand_status_poller`

## Requirements
- R1: Each poll is one transaction with chip select low for exactly 24 clock pulses. MOSI carries, MSB first, 0x0F, then the register address, then filler. The clock idles low, MOSI changes only while the clock is low, and MISO is sampled on the rising edge. The last 8 sampled bits are the register value.
- R2: Between two transactions, chip select stays high for at least one full SPI clock period.
- R3: Every request begins with a read of register 0xC0. Polling ends as soon as bit 0 of that byte is 0. After a poll that reads busy, at least CLK_MHZ clock cycles (one microsecond) pass before the next transaction starts.
- R4: A request runs at most `req_limit` polls, and a limit of 0 behaves as 1. If the last allowed poll still reads busy, the completion reports timeout=1 and result ERROR. If busy clears on the last allowed poll, the completion is a normal one with timeout=0.
- R5: Result encoding is 0 = OK, 1 = REFRESH, 2 = ERROR. Scheme 0 decodes status bits [5:4]: 0 and 1 give OK, 2 gives ERROR, 3 gives REFRESH.
- R6: Scheme 1 decodes status bits [5:4]: 0 gives OK, 1 gives REFRESH, 2 and 3 give ERROR.
- R7: Schemes 2 and 3 read 0xF0 right after 0xC0 on every poll. They build a code from 0xC0 bits [5:4] as bits [3:2] and 0xF0 bits [5:4] as bits [1:0]. Codes 0 to 6 give OK and code 7 gives REFRESH. Scheme 3 also maps codes 12 to 15 to REFRESH. All remaining codes give ERROR. The other schemes never read 0xF0.
- R8: Scheme 4 decodes status bits [5:2] as a 4-bit value: below 7 gives OK, 7 or 12 gives REFRESH, and anything else gives ERROR.
- R9: Schemes 5 and 6 decode status bits [6:4]. In scheme 5, values below 4 give OK, 4 gives REFRESH, and 5 to 7 give ERROR. In scheme 6, values 0, 1 and 3 give OK, 5 gives REFRESH, and the rest give ERROR. Scheme code 7 always gives ERROR.
- R10: `req_ready` is high exactly when the block is idle, and a request is taken when valid and ready are both high. `done` lasts one cycle. `result`, `timeout` and `status` (the last 0xC0 byte) change only together with `done`. A new request can be accepted in the same cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request a status poll |
| req_ready | output | 1 | Block idle; request accepted when valid is also high |
| req_scheme | input | 3 | ECC decoding scheme, 0 to 6 |
| req_limit | input | LIMIT_W | Maximum number of polls (0 treated as 1) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 OK, 1 REFRESH, 2 ERROR |
| timeout | output | 1 | Poll budget ran out with the device still busy |
| status | output | 8 | Last main status byte read |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Two events can fall in the same cycle. One is the completion of a request, where `done` pulses and fresh outputs appear. The other is the acceptance of the next request, because `req_ready` rises in that same cycle. The bench issues every request immediately after the previous one is accepted, so each next request is waiting on the valid line when a completion arrives. It then checks two things: that the completion it reads belongs to the earlier request, and that the transactions which follow carry the new scheme's register sequence. A second collision occurs when the busy flag clears on exactly the last poll the budget allows. The bench arranges this case and expects a normal verdict with no timeout.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  typedef enum logic [1:0] {
    ECC_OK      = 2'd0,
    ECC_REFRESH = 2'd1,
    ECC_ERROR   = 2'd2
  } ecc_res_e;

  localparam logic [7:0] OP_GET_FEATURE = 8'h0F;
  localparam logic [7:0] REG_MAIN       = 8'hC0;
  localparam logic [7:0] REG_AUX        = 8'hF0;

  function automatic logic scheme_uses_aux(input logic [2:0] s);
    return (s == 3'd2) || (s == 3'd3);
  endfunction
endpackage

// File: rtl/nsp_spi_xfer.sv
module nsp_spi_xfer #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] addr,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);
  localparam int HC_W  = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int GAP   = 2 * SCK_HALF;
  localparam int GAP_W = $clog2(GAP + 1);
  localparam int NBITS = 24;

  typedef enum logic [1:0] {X_IDLE, X_SHIFT, X_GAP} xst_e;
  xst_e             st;
  logic [NBITS-1:0] tx;
  logic [4:0]       bitn;
  logic [HC_W-1:0]  hc;
  logic [GAP_W-1:0] gc;

  assign busy = (st != X_IDLE);
  assign mosi = tx[NBITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= X_IDLE;
      tx   <= '0;
      rx   <= '0;
      bitn <= '0;
      hc   <= '0;
      gc   <= '0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        X_IDLE: if (go) begin
          tx   <= {nsp_pkg::OP_GET_FEATURE, addr, 8'h00};
          cs_n <= 1'b0;
          bitn <= '0;
          hc   <= '0;
          st   <= X_SHIFT;
        end
        X_SHIFT: begin
          if (hc == HC_W'(SCK_HALF - 1)) begin
            hc <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
              rx   <= {rx[6:0], miso};
            end else begin
              sclk <= 1'b0;
              tx   <= {tx[NBITS-2:0], 1'b0};
              if (bitn == 5'(NBITS - 1)) begin
                cs_n <= 1'b1;
                done <= 1'b1;
                gc   <= '0;
                st   <= X_GAP;
              end else begin
                bitn <= bitn + 5'd1;
              end
            end
          end else begin
            hc <= hc + HC_W'(1);
          end
        end
        X_GAP: begin
          if (gc == GAP_W'(GAP - 1)) st <= X_IDLE;
          else gc <= gc + GAP_W'(1);
        end
        default: st <= X_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nsp_ecc_classify.sv
module nsp_ecc_classify (
  input  logic [2:0]       scheme,
  input  logic [6:2]       main_f,
  input  logic [1:0]       aux_f,
  output nsp_pkg::ecc_res_e res
);
  import nsp_pkg::*;
  logic [1:0] c2;
  logic [2:0] c3;
  logic [3:0] c4;
  logic [3:0] cx;

  always_comb begin
    c2 = main_f[5:4];
    c3 = main_f[6:4];
    c4 = main_f[5:2];
    cx = {main_f[5:4], aux_f};
    res = ECC_ERROR;
    case (scheme)
      3'd0: res = (c2 == 2'd2) ? ECC_ERROR : (c2 == 2'd3) ? ECC_REFRESH : ECC_OK;
      3'd1: res = (c2 == 2'd0) ? ECC_OK : (c2 == 2'd1) ? ECC_REFRESH : ECC_ERROR;
      3'd2, 3'd3: begin
        if (cx < 4'd7) res = ECC_OK;
        else if (cx == 4'd7) res = ECC_REFRESH;
        else if (scheme == 3'd3 && cx >= 4'd12) res = ECC_REFRESH;
        else res = ECC_ERROR;
      end
      3'd4: begin
        if (c4 < 4'd7) res = ECC_OK;
        else if (c4 == 4'd7 || c4 == 4'd12) res = ECC_REFRESH;
        else res = ECC_ERROR;
      end
      3'd5: res = (c3 < 3'd4) ? ECC_OK : (c3 == 3'd4) ? ECC_REFRESH : ECC_ERROR;
      3'd6: begin
        if (c3 == 3'd0 || c3 == 3'd1 || c3 == 3'd3) res = ECC_OK;
        else if (c3 == 3'd5) res = ECC_REFRESH;
        else res = ECC_ERROR;
      end
      default: res = ECC_ERROR;
    endcase
  end
endmodule

// File: rtl/nsp_poll_ctrl.sv
module nsp_poll_ctrl #(
  parameter int US_CYCLES = 50,
  parameter int LIMIT_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_scheme,
  input  logic [LIMIT_W-1:0] req_limit,
  output logic               x_go,
  output logic [7:0]         x_addr,
  input  logic               x_busy,
  input  logic               x_done,
  input  logic [7:0]         x_rx,
  output logic [2:0]         scheme_q,
  output logic [7:0]         main_q,
  output logic [1:0]         aux_q,
  input  nsp_pkg::ecc_res_e  cls_res,
  output logic               done,
  output nsp_pkg::ecc_res_e  res_q,
  output logic               timeout,
  output logic [7:0]         status
);
  import nsp_pkg::*;
  localparam int DLY_W = $clog2(US_CYCLES + 1);

  typedef enum logic [2:0] {P_IDLE, P_MAIN, P_MAIN_W, P_AUX, P_AUX_W, P_EVAL, P_DELAY} pst_e;
  pst_e               st;
  logic [LIMIT_W-1:0] limit_q;
  logic [LIMIT_W-1:0] polls;
  logic [DLY_W-1:0]   dly;

  assign req_ready = (st == P_IDLE);
  assign x_go      = ((st == P_MAIN) || (st == P_AUX)) && !x_busy;
  assign x_addr    = (st == P_AUX) ? REG_AUX : REG_MAIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_IDLE;
      limit_q  <= '0;
      polls    <= '0;
      dly      <= '0;
      scheme_q <= '0;
      main_q   <= '0;
      aux_q    <= '0;
      done     <= 1'b0;
      res_q    <= ECC_OK;
      timeout  <= 1'b0;
      status   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        P_IDLE: if (req_valid) begin
          scheme_q <= req_scheme;
          limit_q  <= (req_limit == '0) ? LIMIT_W'(1) : req_limit;
          polls    <= '0;
          st       <= P_MAIN;
        end
        P_MAIN:   if (!x_busy) st <= P_MAIN_W;
        P_MAIN_W: if (x_done) begin
          main_q <= x_rx;
          polls  <= polls + LIMIT_W'(1);
          st     <= scheme_uses_aux(scheme_q) ? P_AUX : P_EVAL;
        end
        P_AUX:   if (!x_busy) st <= P_AUX_W;
        P_AUX_W: if (x_done) begin
          aux_q <= x_rx[5:4];
          st    <= P_EVAL;
        end
        P_EVAL: begin
          if (!main_q[0]) begin
            done    <= 1'b1;
            res_q   <= cls_res;
            timeout <= 1'b0;
            status  <= main_q;
            st      <= P_IDLE;
          end else if (polls >= limit_q) begin
            done    <= 1'b1;
            res_q   <= ECC_ERROR;
            timeout <= 1'b1;
            status  <= main_q;
            st      <= P_IDLE;
          end else begin
            dly <= '0;
            st  <= P_DELAY;
          end
        end
        P_DELAY: begin
          if (dly == DLY_W'(US_CYCLES - 1)) st <= P_MAIN;
          else dly <= dly + DLY_W'(1);
        end
        default: st <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_status_poller.sv
module nand_status_poller #(
  parameter int CLK_MHZ  = 50,
  parameter int SCK_HALF = 2,
  parameter int LIMIT_W  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_scheme,
  input  logic [LIMIT_W-1:0] req_limit,
  output logic               done,
  output logic [1:0]         result,
  output logic               timeout,
  output logic [7:0]         status,
  output logic               spi_sclk,
  output logic               spi_cs_n,
  output logic               spi_mosi,
  input  logic               spi_miso
);
  localparam int US_CYCLES = CLK_MHZ;

  logic              x_go, x_busy, x_done;
  logic [7:0]        x_addr, x_rx;
  logic [2:0]        scheme_q;
  logic [7:0]        main_q;
  logic [1:0]        aux_q;
  nsp_pkg::ecc_res_e cls_res, res_q;

  nsp_spi_xfer #(.SCK_HALF(SCK_HALF)) u_xfer (
    .clk(clk), .rst_n(rst_n), .go(x_go), .addr(x_addr), .busy(x_busy),
    .done(x_done), .rx(x_rx), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .miso(spi_miso)
  );

  nsp_ecc_classify u_cls (
    .scheme(scheme_q), .main_f(main_q[6:2]), .aux_f(aux_q), .res(cls_res)
  );

  nsp_poll_ctrl #(.US_CYCLES(US_CYCLES), .LIMIT_W(LIMIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_scheme(req_scheme), .req_limit(req_limit), .x_go(x_go),
    .x_addr(x_addr), .x_busy(x_busy), .x_done(x_done), .x_rx(x_rx),
    .scheme_q(scheme_q), .main_q(main_q), .aux_q(aux_q), .cls_res(cls_res),
    .done(done), .res_q(res_q), .timeout(timeout), .status(status)
  );

  assign result = res_q;
endmodule

// File: rtl/nand_status_poller_chk.sv
module nand_status_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic [1:0] result,
  input logic       timeout,
  input logic [7:0] status,
  input logic       spi_sclk,
  input logic       spi_cs_n,
  input logic       spi_mosi
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R1
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi)); // R1
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !timeout) |-> !status[0]); // R3
  AST_TIMEOUT_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> (result == 2'd2 && status[0])); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(timeout) && $stable(status))); // R10
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
endmodule

bind nand_status_poller nand_status_poller_chk u_chk (.*);

// File: tb/tb_nand_status_poller.sv
module tb_nand_status_poller;
  localparam int CLK_MHZ = 50;
  localparam int SCK_HALF = 2;
  localparam int LIMIT_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_scheme = '0;
  logic [LIMIT_W-1:0] req_limit = '0;
  logic req_ready, done, timeout, spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;
  logic [1:0] result;
  logic [7:0] status;

  always #10 clk = ~clk;

  nand_status_poller #(.CLK_MHZ(CLK_MHZ), .SCK_HALF(SCK_HALF), .LIMIT_W(LIMIT_W)) dut (.*);

  int total = 0, bad = 0, cyc = 0, same_cycle = 0;
  bit finished = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic int ref_class(input int s, input int m, input int a);
    int f2 = (m >> 4) & 3;
    int f3 = (m >> 4) & 7;
    int f4 = (m >> 2) & 15;
    int cx = (f2 << 2) | ((a >> 4) & 3);
    case (s)
      0: return (f2 == 2) ? 2 : (f2 == 3) ? 1 : 0;
      1: return (f2 == 0) ? 0 : (f2 == 1) ? 1 : 2;
      2: return (cx < 7) ? 0 : (cx == 7) ? 1 : 2;
      3: return (cx < 7) ? 0 : (cx == 7 || cx >= 12) ? 1 : 2;
      4: return (f4 < 7) ? 0 : (f4 == 7 || f4 == 12) ? 1 : 2;
      5: return (f3 < 4) ? 0 : (f3 == 4) ? 1 : 2;
      6: return (f3 == 0 || f3 == 1 || f3 == 3) ? 0 : (f3 == 5) ? 1 : 2;
      default: return 2;
    endcase
  endfunction

  // device model queues and expectation queues
  logic [7:0] dev_main[$], dev_aux[$], exp_addr[$];
  int exp_res[$], exp_to[$], exp_st[$];
  string exp_tag[$];
  logic [7:0] pm[16], pa[16];
  bit new_req = 0;

  // SPI slave model (mode 0)
  int fe_cnt = 0, re_cnt = 0, prev_rise = -1000, this_fall = 0;
  logic [23:0] mosi_sh = '0;
  logic [7:0] cur = 8'h00;

  always @(negedge spi_cs_n) begin
    fe_cnt = 0; re_cnt = 0; mosi_sh = '0;
    this_fall = cyc;
    chk(this_fall - prev_rise >= 2 * SCK_HALF, "R2 cs high gap", this_fall - prev_rise, 2 * SCK_HALF);
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    re_cnt++;
    mosi_sh = {mosi_sh[22:0], spi_mosi};
    if (re_cnt == 16) begin
      if (mosi_sh[7:0] == 8'hF0) cur = (dev_aux.size() > 0) ? dev_aux.pop_front() : 8'h00;
      else cur = (dev_main.size() > 0) ? dev_main.pop_front() : 8'h01;
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    fe_cnt++;
    if (fe_cnt >= 16 && fe_cnt < 24) spi_miso = cur[23 - fe_cnt];
  end

  always @(posedge spi_cs_n) if (rst_n) begin
    logic [7:0] ea;
    ea = (exp_addr.size() > 0) ? exp_addr.pop_front() : 8'hXX;
    chk(re_cnt == 24, "R1 clock pulses", re_cnt, 24);
    chk(mosi_sh[23:16] == 8'h0F, "R1 opcode", mosi_sh[23:16], 8'h0F);
    chk(mosi_sh[15:8] == ea, "R1/R7 register address", mosi_sh[15:8], ea);
    if (mosi_sh[15:8] == 8'hC0) begin
      if (!new_req)
        chk(this_fall - prev_rise >= CLK_MHZ, "R3 inter-poll wait", this_fall - prev_rise, CLK_MHZ);
      new_req = 0;
    end
    prev_rise = cyc;
  end

  // result reference comparison on every clock
  always @(negedge clk) if (rst_n && done) begin
    if (exp_res.size() == 0) chk(0, "R10 unexpected done", 1, 0);
    else begin
      int er, et, es;
      string tg;
      er = exp_res.pop_front(); et = exp_to.pop_front();
      es = exp_st.pop_front(); tg = exp_tag.pop_front();
      chk(result == er, {tg, " result"}, result, er);
      chk(timeout == et, {tg, " timeout"}, timeout, et);
      chk(status == es, {tg, " status"}, status, es);
    end
  end

  task automatic go(input int sch, input int lim, input int np, input string tag);
    int eff = (lim == 0) ? 1 : lim;
    int used = eff;
    int hit = -1;
    for (int i = 0; i < np && i < eff; i++)
      if (!pm[i][0] && hit < 0) hit = i;
    if (hit >= 0) used = hit + 1;
    for (int i = 0; i < used; i++) begin
      dev_main.push_back(i < np ? pm[i] : 8'h01);
      exp_addr.push_back(8'hC0);
      if (sch == 2 || sch == 3) begin
        dev_aux.push_back(pa[i]);
        exp_addr.push_back(8'hF0);
      end
    end
    if (hit >= 0) begin
      exp_res.push_back(ref_class(sch, pm[hit], pa[hit]));
      exp_to.push_back(0);
      exp_st.push_back(pm[hit]);
    end else begin
      exp_res.push_back(2);
      exp_to.push_back(1);
      exp_st.push_back(used - 1 < np ? pm[used - 1] : 8'h01);
    end
    exp_tag.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (done) same_cycle++;
    req_scheme = 3'(sch);
    req_limit = LIMIT_W'(lim);
    req_valid = 1'b1;
    new_req = 1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic one(input int sch, input logic [7:0] m, input logic [7:0] a, input string tag);
    pm[0] = m; pa[0] = a;
    go(sch, 4, 1, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
    chk(done == 1'b0 && timeout == 1'b0, "R10 reset outputs", {done, timeout}, 0);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 reset bus idle", {spi_cs_n, spi_sclk}, 2);

    one(0, 8'h00, 8'h00, "R5 s0 v0");
    one(0, 8'h10, 8'h00, "R5 s0 v1");
    one(0, 8'h20, 8'h00, "R5 s0 v2");
    one(0, 8'h30, 8'h00, "R5 s0 v3");
    one(1, 8'h00, 8'h00, "R6 s1 v0");
    one(1, 8'h10, 8'h00, "R6 s1 v1");
    one(1, 8'h20, 8'h00, "R6 s1 v2");
    one(1, 8'h30, 8'h00, "R6 s1 v3");
    one(2, 8'h10, 8'h30, "R7 s2 code7");
    one(2, 8'h10, 8'h20, "R7 s2 code6");
    one(2, 8'h30, 8'h00, "R7 s2 code12");
    one(3, 8'h30, 8'h00, "R7 s3 code12");
    one(3, 8'h30, 8'h30, "R7 s3 code15");
    one(3, 8'h20, 8'h00, "R7 s3 code8");
    one(3, 8'h10, 8'h30, "R7 s3 code7");
    one(4, 8'h18, 8'h00, "R8 s4 v6");
    one(4, 8'h1C, 8'h00, "R8 s4 v7");
    one(4, 8'h30, 8'h00, "R8 s4 v12");
    one(4, 8'h20, 8'h00, "R8 s4 v8");
    one(5, 8'h30, 8'h00, "R9 s5 v3");
    one(5, 8'h40, 8'h00, "R9 s5 v4");
    one(5, 8'h50, 8'h00, "R9 s5 v5");
    one(6, 8'h30, 8'h00, "R9 s6 v3");
    one(6, 8'h50, 8'h00, "R9 s6 v5");
    one(6, 8'h20, 8'h00, "R9 s6 v2");
    one(6, 8'h40, 8'h00, "R9 s6 v4");
    one(7, 8'h00, 8'h00, "R9 scheme7");

    pm[0] = 8'h01; pm[1] = 8'h21; pm[2] = 8'h30;
    go(0, 5, 3, "R3 busy then ready");
    pm[0] = 8'h01; pm[1] = 8'h11; pm[2] = 8'h31;
    go(0, 3, 3, "R4 timeout");
    pm[0] = 8'h01; pm[1] = 8'h01; pm[2] = 8'h10;
    go(1, 3, 3, "R4 ready on last poll");
    pm[0] = 8'h01;
    go(0, 0, 1, "R4 limit zero");
    pm[0] = 8'h01; pa[0] = 8'h30; pm[1] = 8'h10; pa[1] = 8'h30;
    go(2, 4, 2, "R7 aux each poll");

    while (exp_res.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(exp_addr.size() == 0, "R1 transaction count", exp_addr.size(), 0);
    chk(same_cycle > 0, "R10 accept in done cycle", same_cycle, 1);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "R10 watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule